// File: doc/BRIEF.md
# Conditional Upper-Word AND Unit for a DSP Datapath

This block carries out one DSP logical operation: a bitwise AND of the upper 16-bit halves of two source registers. The result goes to the upper half of a destination register. The lower half of the destination is cleared, and so are its guard bits when the destination is an accumulator. The operation comes in three forms:

- an always-execute form, which also updates the status flags;
- a form that runs only when the status DC bit is set;
- a form that runs only when the DC bit is clear.

Neither conditional form ever touches the flags.

Each accepted instruction completes on the clock edge that samples it. The unit holds eight data registers:

- two 40-bit accumulators;
- two X registers, two Y registers and two M registers, each 32 bits wide.

A load port lets the surrounding datapath write a register directly, and a combinational read port exposes any register.

Top module: `dsp_and_unit`

## Requirements
- R1: An instruction has an effect only when all three fields match. Bits 31:26 must be 111110 and bits 15:10 must be 100101. The condition field cc (bits 9:8) must be 01, 10 or 11. Any other word, including one with cc = 00, changes no register and no flag.
- R2: An executed instruction writes the destination as follows. Bits 31:16 receive Sx[31:16] & Sy[31:16] and bits 15:0 become zero. The new value is readable right after the clock edge that samples the instruction.
- R3: When the destination is an accumulator, its guard bits 39:32 are written as zero. Only accumulators keep guard bits. Every other register reads bits 39:32 as zero.
- R4: The Sx field (bits 7:6) selects a source as 00→X0, 01→X1, 10→A0, 11→A1. The Sy field (bits 5:4) selects a source as 00→Y0, 01→Y1, 10→M0, 11→M1.
- R5: The Dz field (bits 3:0) selects the destination as 0→X0, 1→X1, 2→Y0, 3→Y1, 4→M0, 5→M1, 6→A0, 7→A1. Codes 8 to 15 make the instruction a no-op, with no register write and no flag change. The same 0 to 7 numbering is used on the load and read ports.
- R6: The cc = 01 form updates the flags from the 16-bit AND result only:
  - N takes result bit 15, which is destination bit 31.
  - Z is set when the result is zero.
  - V is cleared.
  - GT equals (not N and not Z).
- R7: In the cc = 01 form, DC depends on the cs_mode input. It takes N when cs_mode = 001, takes Z when cs_mode = 010, and is cleared for every other cs_mode value.
- R8: The cc = 10 form executes only while DC = 1, and the cc = 11 form executes only while DC = 0. When the condition fails, no register is written.
- R9: The cc = 10 and cc = 11 forms never change DC, N, Z, V or GT, even when they execute.
- R10: When wr_en is high, the load port writes wr_data to register wr_sel, keeping the guard bits only for accumulators. If the same register is also an instruction's destination in that cycle, the instruction result wins. If the registers differ, both writes take place.
- R11: Reset clears all registers and all flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | Instruction word present this cycle |
| instr | input | 32 | Two-halfword instruction word |
| cs_mode | input | 3 | Selects which condition DC reflects |
| wr_en | input | 1 | Load port write enable |
| wr_sel | input | 3 | Load port register index |
| wr_data | input | WORD_W+GUARD_W | Load port data |
| rd_sel | input | 3 | Read port register index |
| rd_data | output | WORD_W+GUARD_W | Read port data |
| flag_dc | output | 1 | DC status bit |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_gt | output | 1 | Greater-than flag |

## Verification
Two writes can land in the same cycle: the instruction writeback and a load-port write. The bench raises wr_en on the same clock that an executing instruction is sampled. It does this once with both aimed at the same accumulator, and once with the load aimed at a different register. Afterwards it reads back both registers through the read port. The shared register must hold the zero-guarded AND result, and the other register must hold the loaded value. The condition gate and the flag update are also checked against each other: a conditional form that executes must leave flags unchanged that the same result would have changed in the cc = 01 form.

// File: rtl/dsp_and_unit.sv
module dsp_and_unit #(
  parameter int WORD_W  = 32,
  parameter int GUARD_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       instr_valid,
  input  logic [31:0]                instr,
  input  logic [2:0]                 cs_mode,
  input  logic                       wr_en,
  input  logic [2:0]                 wr_sel,
  input  logic [WORD_W+GUARD_W-1:0]  wr_data,
  input  logic [2:0]                 rd_sel,
  output logic [WORD_W+GUARD_W-1:0]  rd_data,
  output logic                       flag_dc,
  output logic                       flag_n,
  output logic                       flag_z,
  output logic                       flag_v,
  output logic                       flag_gt
);
  localparam int ACC_W  = WORD_W + GUARD_W;
  localparam int HALF   = WORD_W / 2;
  localparam int NREG   = 8;
  localparam int A0_IDX = 6;
  localparam int A1_IDX = 7;

  logic [ACC_W-1:0] rf [NREG];

  logic [1:0] cc, xx, yy;
  logic [3:0] dz;
  logic       hdr_ok, cond_ok, dz_ok, ins_wr, flag_upd;
  logic [2:0] sx_idx, sy_idx;
  logic [HALF-1:0] and_hi;
  logic [ACC_W-1:0] res_full;
  logic       n_w, z_w, dc_w;
  logic       unused_dontcare;

  assign cc = instr[9:8];
  assign xx = instr[7:6];
  assign yy = instr[5:4];
  assign dz = instr[3:0];
  assign unused_dontcare = ^instr[25:16];

  assign hdr_ok  = (instr[31:26] == 6'b111110) && (instr[15:10] == 6'b100101) && (cc != 2'b00);
  assign cond_ok = (cc == 2'b01) || (cc == 2'b10 && flag_dc) || (cc == 2'b11 && !flag_dc);
  assign dz_ok   = !dz[3];
  assign ins_wr  = instr_valid && hdr_ok && cond_ok && dz_ok;
  assign flag_upd = ins_wr && (cc == 2'b01);

  always_comb begin
    case (xx)
      2'b00:   sx_idx = 3'd0;
      2'b01:   sx_idx = 3'd1;
      2'b10:   sx_idx = 3'(A0_IDX);
      default: sx_idx = 3'(A1_IDX);
    endcase
    case (yy)
      2'b00:   sy_idx = 3'd2;
      2'b01:   sy_idx = 3'd3;
      2'b10:   sy_idx = 3'd4;
      default: sy_idx = 3'd5;
    endcase
  end

  assign and_hi   = rf[sx_idx][WORD_W-1:HALF] & rf[sy_idx][WORD_W-1:HALF];
  assign res_full = {{GUARD_W{1'b0}}, and_hi, {HALF{1'b0}}};

  assign n_w = and_hi[HALF-1];
  assign z_w = (and_hi == '0);

  always_comb begin
    case (cs_mode)
      3'b001:  dc_w = n_w;
      3'b010:  dc_w = z_w;
      default: dc_w = 1'b0;
    endcase
  end

  genvar g;
  generate
    for (g = 0; g < NREG; g++) begin : g_reg
      localparam bit HAS_GUARD = (g == A0_IDX) || (g == A1_IDX);
      logic [ACC_W-1:0] load_val;
      if (HAS_GUARD) begin : g_acc
        assign load_val = wr_data;
      end else begin : g_plain
        assign load_val = {{GUARD_W{1'b0}}, wr_data[WORD_W-1:0]};
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          rf[g] <= '0;
        else if (ins_wr && dz[2:0] == 3'(g))
          rf[g] <= res_full;
        else if (wr_en && wr_sel == 3'(g))
          rf[g] <= load_val;
      end
    end
  endgenerate

  assign rd_data = rf[rd_sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_dc <= 1'b0;
      flag_n  <= 1'b0;
      flag_z  <= 1'b0;
      flag_v  <= 1'b0;
      flag_gt <= 1'b0;
    end else if (flag_upd) begin
      flag_dc <= dc_w;
      flag_n  <= n_w;
      flag_z  <= z_w;
      flag_v  <= 1'b0;
      flag_gt <= !n_w && !z_w;
    end
  end
endmodule

module dsp_and_unit_chk #(
  parameter int WORD_W  = 32,
  parameter int GUARD_W = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      instr_valid,
  input logic [31:0]               instr,
  input logic                      wr_en,
  input logic                      flag_dc,
  input logic                      flag_n,
  input logic                      flag_z,
  input logic                      flag_v,
  input logic                      flag_gt,
  input logic [WORD_W+GUARD_W-1:0] acc0,
  input logic [WORD_W+GUARD_W-1:0] acc1
);
  localparam int ACC_W = WORD_W + GUARD_W;
  localparam int HALF  = WORD_W / 2;

  logic hdr, unused_bits;
  logic [4:0] flags;
  assign hdr   = instr[31:26] == 6'b111110 && instr[15:10] == 6'b100101 && instr[9:8] != 2'b00;
  assign flags = {flag_dc, flag_n, flag_z, flag_v, flag_gt};
  assign unused_bits = ^instr[25:16];

  // R9
  cond_flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid && hdr && instr[9] |=> $stable(flags));

  // R1
  bad_word_flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid && !hdr |=> $stable(flags));

  // R6
  uncond_flag_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid && hdr && instr[9:8] == 2'b01 && !instr[3]
    |=> !flag_v && !(flag_n && flag_z) && (flag_gt == (!flag_n && !flag_z)));

  // R3
  acc0_guard_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid && hdr && instr[9:8] == 2'b01 && instr[3:0] == 4'd6
    |=> acc0[ACC_W-1:WORD_W] == '0 && acc0[HALF-1:0] == '0);

  // R8
  cond_false_acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid && hdr && instr[9:8] == 2'b10 && !flag_dc && !wr_en
    |=> $stable(acc0) && $stable(acc1));
endmodule

bind dsp_and_unit dsp_and_unit_chk #(.WORD_W(WORD_W), .GUARD_W(GUARD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr), .wr_en(wr_en),
  .flag_dc(flag_dc), .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_gt(flag_gt),
  .acc0(rf[6]), .acc1(rf[7])
);

// File: tb/sim_dsp_and_unit.sv
module sim_dsp_and_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [2:0]  cs_mode = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [39:0] wr_data = '0;
  logic [2:0]  rd_sel = '0;
  logic [39:0] rd_data;
  logic flag_dc, flag_n, flag_z, flag_v, flag_gt;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dsp_and_unit u0 (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr), .cs_mode(cs_mode),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .flag_dc(flag_dc), .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_gt(flag_gt)
  );

  // {xx, yy, dz, cs, sx_value, sy_value}
  localparam int NV = 8;
  localparam logic [74:0] VEC [NV] = '{
    {2'd0, 2'd0, 4'd6, 3'd1, 32'hF0F0_1234, 32'hFF00_5678},
    {2'd1, 2'd1, 4'd7, 3'd2, 32'h1234_FFFF, 32'h4321_FFFF},
    {2'd2, 2'd2, 4'd0, 3'd2, 32'h0F0F_0000, 32'hF0F0_FFFF},
    {2'd3, 2'd3, 4'd1, 3'd0, 32'hFFFF_0001, 32'h8001_0002},
    {2'd0, 2'd2, 4'd2, 3'd1, 32'h7FFF_AAAA, 32'hFFFF_5555},
    {2'd1, 2'd3, 4'd4, 3'd3, 32'hAAAA_0000, 32'h5555_0000},
    {2'd0, 2'd0, 4'd5, 3'd4, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {2'd2, 2'd1, 4'd6, 3'd2, 32'h0001_0000, 32'h0001_0000}
  };

  function automatic logic [31:0] mk(input logic [1:0] cc, input logic [1:0] xx,
                                      input logic [1:0] yy, input logic [3:0] dz);
    return {6'b111110, 10'h2A5, 6'b100101, cc, xx, yy, dz};
  endfunction

  function automatic logic [2:0] sx_of(input logic [1:0] xx);
    case (xx) 2'd0: return 3'd0; 2'd1: return 3'd1; 2'd2: return 3'd6; default: return 3'd7; endcase
  endfunction

  function automatic logic [2:0] sy_of(input logic [1:0] yy);
    return 3'd2 + {1'b0, yy};
  endfunction

  function automatic logic [39:0] fit(input logic [2:0] idx, input logic [39:0] v);
    return (idx >= 3'd6) ? v : {8'h00, v[31:0]};
  endfunction

  function automatic logic [4:0] flags_now();
    return {flag_dc, flag_n, flag_z, flag_v, flag_gt};
  endfunction

  task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic load(input logic [2:0] idx, input logic [39:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = idx; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic issue(input logic [31:0] w, input logic [2:0] cs);
    @(negedge clk);
    instr_valid = 1'b1; instr = w; cs_mode = cs;
    @(negedge clk);
    instr_valid = 1'b0; instr = '0;
  endtask

  task automatic rd(input logic [2:0] idx, output logic [39:0] v);
    rd_sel = idx;
    #1;
    v = rd_data;
  endtask

  task automatic snap(output logic [39:0] s [8]);
    for (int i = 0; i < 8; i++) begin
      logic [39:0] t;
      rd(3'(i), t);
      s[i] = t;
    end
  endtask

  task automatic same_regs(input string req, input logic [39:0] s [8]);
    for (int i = 0; i < 8; i++) begin
      logic [39:0] t;
      rd(3'(i), t);
      chk(req, t, s[i]);
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [39:0] v, w;
    logic [39:0] s [8];
    logic [4:0]  f0;

    repeat (3) @(negedge clk);
    // R11 reset state
    for (int i = 0; i < 8; i++) begin
      rd(3'(i), v);
      chk("R11 register reset", v, 40'h0);
    end
    chk("R11 flag reset", {35'h0, flags_now()}, 40'h0);
    rst_n = 1'b1;

    // R10 R3 plain register drops guard bits on load
    load(3'd0, 40'hAB_1234_5678);
    rd(3'd0, v);
    chk("R10 R3 plain load", v, 40'h00_1234_5678);

    // R2 R4 R5 R6 R7 table walk
    for (int k = 0; k < NV; k++) begin
      logic [1:0] xx, yy; logic [3:0] dz; logic [2:0] cs;
      logic [31:0] a, b; logic [15:0] r; logic n, z, dc;
      {xx, yy, dz, cs, a, b} = VEC[k];
      load(dz[2:0], 40'hFF_FFFF_FFFF);
      load(sx_of(xx), {8'hAB, a});
      load(sy_of(yy), {8'hCD, b});
      issue(mk(2'b01, xx, yy, dz), cs);
      r = a[31:16] & b[31:16];
      n = r[15]; z = (r == 16'h0);
      dc = (cs == 3'd1) ? n : (cs == 3'd2) ? z : 1'b0;
      rd(dz[2:0], v);
      chk("R2 R3 R4 R5 result", v, {8'h00, r, 16'h0000});
      chk("R6 R7 flags", {35'h0, flags_now()}, {35'h0, dc, n, z, 1'b0, !n && !z});
    end

    // set DC = 1 via zero result with cs_mode = 010
    load(3'd0, 40'h0000_0000); load(3'd2, 40'hFFFF_FFFF);
    issue(mk(2'b01, 2'd0, 2'd0, 4'd1), 3'd2);
    chk("R7 dc from Z", {39'h0, flag_dc}, 40'h1);

    // R8 R9 cc=10 executes while DC=1, flags hold
    f0 = flags_now();
    load(3'd0, 40'hFFFF_1111); load(3'd2, 40'h0F0F_2222); load(3'd7, 40'hEE_EEEE_EEEE);
    issue(mk(2'b10, 2'd0, 2'd0, 4'd7), 3'd1);
    rd(3'd7, v);
    chk("R8 cc10 true writes", v, 40'h00_0F0F_0000);
    chk("R9 cc10 flags hold", {35'h0, flags_now()}, {35'h0, f0});

    // R8 cc=11 skipped while DC=1
    load(3'd6, 40'h77_7777_7777);
    issue(mk(2'b11, 2'd0, 2'd0, 4'd6), 3'd1);
    rd(3'd6, v);
    chk("R8 cc11 false no write", v, 40'h77_7777_7777);
    chk("R9 cc11 false flags hold", {35'h0, flags_now()}, {35'h0, f0});

    // clear DC via nonzero result
    issue(mk(2'b01, 2'd0, 2'd0, 4'd1), 3'd2);
    chk("R7 dc cleared", {39'h0, flag_dc}, 40'h0);
    f0 = flags_now();

    // R8 cc=10 skipped, cc=11 executes while DC=0
    issue(mk(2'b10, 2'd0, 2'd0, 4'd6), 3'd2);
    rd(3'd6, v);
    chk("R8 cc10 false no write", v, 40'h77_7777_7777);
    issue(mk(2'b11, 2'd0, 2'd0, 4'd6), 3'd2);
    rd(3'd6, v);
    chk("R8 cc11 true writes", v, 40'h00_0F0F_0000);
    chk("R9 cc11 true flags hold", {35'h0, flags_now()}, {35'h0, f0});

    // R1 malformed words
    load(3'd6, 40'h55_5555_5555);
    snap(s);
    issue(mk(2'b01, 2'd0, 2'd0, 4'd6) ^ 32'h0400_0000, 3'd1);
    issue(mk(2'b01, 2'd0, 2'd0, 4'd6) ^ 32'h0000_1000, 3'd1);
    issue(mk(2'b00, 2'd0, 2'd0, 4'd6), 3'd1);
    same_regs("R1 malformed no write", s);
    chk("R1 malformed flags hold", {35'h0, flags_now()}, {35'h0, f0});

    // R5 unused destination codes
    issue(mk(2'b01, 2'd0, 2'd0, 4'd8), 3'd2);
    issue(mk(2'b01, 2'd0, 2'd0, 4'd14), 3'd2);
    same_regs("R5 unused dz no write", s);
    chk("R5 unused dz flags hold", {35'h0, flags_now()}, {35'h0, f0});

    // R10 same-cycle collision, same register: instruction wins
    @(negedge clk);
    instr_valid = 1'b1; instr = mk(2'b01, 2'd0, 2'd0, 4'd6); cs_mode = 3'd1;
    wr_en = 1'b1; wr_sel = 3'd6; wr_data = 40'h12_3456_789A;
    @(negedge clk);
    instr_valid = 1'b0; wr_en = 1'b0;
    rd(3'd6, v);
    chk("R10 collision instruction wins", v, 40'h00_0F0F_0000);

    // R10 same cycle, different registers: both written
    @(negedge clk);
    instr_valid = 1'b1; instr = mk(2'b01, 2'd0, 2'd0, 4'd7); cs_mode = 3'd1;
    wr_en = 1'b1; wr_sel = 3'd6; wr_data = 40'h9A_BCDE_F012;
    @(negedge clk);
    instr_valid = 1'b0; wr_en = 1'b0;
    rd(3'd6, v); rd(3'd7, w);
    chk("R10 parallel load", v, 40'h9A_BCDE_F012);
    chk("R10 parallel instruction", w, 40'h00_0F0F_0000);
    chk("R3 accumulator load keeps guard", fit(3'd6, 40'h9A_BCDE_F012), v);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule